// File: doc/BRIEF.md
# Staggered Half-Width Integer ALU

This block is a two-stage integer ALU that splits each operand into a lower and an upper half and works on them in consecutive cycles. The lower half of the result appears one cycle after issue. The upper half and the carry-out appear one cycle later. The block is meant to run at twice the rate of the logic around it, so its two stages fit inside one cycle of the outer core.

Only operations whose lower result half depends on nothing but the lower operand halves are supported: add, subtract, and, or, xor, and a left shift by a small amount. For add and subtract, the carry leaving the lower half is held in a register and fed into the upper half in the next cycle. For the left shift, the bits pushed out of the lower half are held in a register and merged into the upper half.

A dependent operation can take the previous result as operand A through the forwarding input. It is issued in the very next cycle and uses the lower half while the upper half is still being computed. The upper-half path reaches the dependent operation one cycle later, which is exactly when its own upper half is computed. A chain of dependent operations therefore runs at one operation per cycle with a one-cycle effective latency.

A small controller tracks how full the pipeline is with four states:
- `ST_IDLE`: both stages are empty.
- `ST_FILL`: only the lower stage holds an operation.
- `ST_FULL`: both stages hold operations.
- `ST_DRAIN`: only the upper stage holds an operation.

Its transitions depend only on whether an operation is issued:
- From `ST_IDLE`: issue moves to `ST_FILL`; no issue stays in `ST_IDLE`.
- From `ST_FILL`: issue moves to `ST_FULL`; no issue moves to `ST_DRAIN`.
- From `ST_FULL`: issue stays in `ST_FULL`; no issue moves to `ST_DRAIN`.
- From `ST_DRAIN`: issue moves to `ST_FILL`; no issue moves to `ST_IDLE`.

Top module: `stag_alu`

## Requirements
- R1: While `rst_n` is low, and in the cycle after reset is released with no issue, `lo_valid` and `hi_valid` are 0, whatever the other inputs do.
- R2: `lo_valid` is 1 exactly in the cycles that follow a clock edge where `in_valid` was 1. `hi_valid` is 1 exactly in the cycles that follow an edge where `lo_valid` was 1. Back-to-back issue keeps both high.
- R3: Op code 0 (add): {`hi_cout`, `hi_data`, `lo_data`} equals A + B, where A is the full operand A and B is `in_b`.
- R4: Op code 1 (subtract): {`hi_data`, `lo_data`} equals A − B modulo 2^WIDTH. `hi_cout` is 1 when A ≥ B (unsigned), meaning no borrow.
- R5: Op codes 2, 3 and 4 give A AND B, A OR B and A XOR B respectively, over both halves.
- R6: Op code 5 (left shift): the full result is A shifted left by `in_b[SHAMT_W-1:0]`, truncated to WIDTH bits. Bits leaving the lower half appear in the upper half.
- R7: When `in_fwd_a` is 1 and `lo_valid` is 1 at issue, operand A is the complete WIDTH-bit result of the operation issued one cycle earlier. This holds even across carries and shift spills into that result's upper half, and along chains of any length.
- R8: When `in_fwd_a` is 1 but `lo_valid` is 0 at issue, the request is ignored and `in_a` is used as operand A.
- R9: Undefined op codes 6 and 7 give an all-zero result and `hi_cout` 0.
- R10: `hi_cout` is 0 for every op other than add and subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ALU clock (the fast clock) |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Issue an operation this cycle |
| in_op | input | 3 | Op code: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 shl |
| in_a | input | WIDTH | Operand A |
| in_b | input | WIDTH | Operand B; low SHAMT_W bits give the shift amount |
| in_fwd_a | input | 1 | Take operand A from the previous result |
| lo_valid | output | 1 | Lower result half is valid |
| lo_data | output | WIDTH/2 | Lower result half |
| hi_valid | output | 1 | Upper result half and carry are valid |
| hi_data | output | WIDTH/2 | Upper result half |
| hi_cout | output | 1 | Carry-out (add) or no-borrow (sub) |

## Verification
Faults in the stored carry or the stored shift spill never show in `lo_data`. They show only in `hi_data` or `hi_cout`, in the cycle after the lower half, and only for operand pairs whose lower halves overflow or spill. For this reason the operand sweep crosses the half boundary with many carries and spills.

A wrong forwarding selection damages the dependent result in its lower half first, one cycle after issue. A mistimed upper forwarding path damages only the dependent result's upper half, one cycle after that. Long dependent chains make either fault spread into every later result.

A wrong controller state shows at once as a valid flag that is out of step with the issue pattern. Bubbles are inserted into the stimulus so that every state and transition is visited.

// File: rtl/stag_alu_pkg.sv
package stag_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_SHL = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_FULL,
        ST_DRAIN
    } pipe_state_e;

endpackage

// File: rtl/stag_ctrl.sv
module stag_ctrl
    import stag_alu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    output logic lo_live,
    output logic hi_live
);

    pipe_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = issue ? ST_FILL : ST_IDLE;
            ST_FILL:  state_d = issue ? ST_FULL : ST_DRAIN;
            ST_FULL:  state_d = issue ? ST_FULL : ST_DRAIN;
            ST_DRAIN: state_d = issue ? ST_FILL : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        lo_live = 1'b0;
        hi_live = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin lo_live = 1'b0; hi_live = 1'b0; end
            ST_FILL:  begin lo_live = 1'b1; hi_live = 1'b0; end
            ST_FULL:  begin lo_live = 1'b1; hi_live = 1'b1; end
            ST_DRAIN: begin lo_live = 1'b0; hi_live = 1'b1; end
            default:  begin lo_live = 1'b0; hi_live = 1'b0; end
        endcase
    end

endmodule

// File: rtl/stag_lo_stage.sv
module stag_lo_stage
    import stag_alu_pkg::*;
#(
    parameter int HALF    = 16,
    parameter int SHAMT_W = 4
) (
    input  alu_op_e             op,
    input  logic [HALF-1:0]     a_lo,
    input  logic [HALF-1:0]     b_lo,
    input  logic [SHAMT_W-1:0]  sh,
    output logic [HALF-1:0]     res_lo,
    output logic                carry,
    output logic [HALF-1:0]     spill
);

    logic [HALF:0]     sum;
    logic [2*HALF-1:0] ext;

    always_comb begin
        ext    = {{HALF{1'b0}}, a_lo} << sh;
        sum    = '0;
        res_lo = '0;
        carry  = 1'b0;
        spill  = '0;
        case (op)
            OP_ADD: begin
                sum    = {1'b0, a_lo} + {1'b0, b_lo};
                res_lo = sum[HALF-1:0];
                carry  = sum[HALF];
            end
            OP_SUB: begin
                sum    = {1'b0, a_lo} + {1'b0, ~b_lo} + {{HALF{1'b0}}, 1'b1};
                res_lo = sum[HALF-1:0];
                carry  = sum[HALF];
            end
            OP_AND: res_lo = a_lo & b_lo;
            OP_OR:  res_lo = a_lo | b_lo;
            OP_XOR: res_lo = a_lo ^ b_lo;
            OP_SHL: begin
                res_lo = ext[HALF-1:0];
                spill  = ext[2*HALF-1:HALF];
            end
            default: res_lo = '0;
        endcase
    end

endmodule

// File: rtl/stag_hi_stage.sv
module stag_hi_stage
    import stag_alu_pkg::*;
#(
    parameter int HALF    = 16,
    parameter int SHAMT_W = 4
) (
    input  alu_op_e             op,
    input  logic [HALF-1:0]     a_hi,
    input  logic [HALF-1:0]     b_hi,
    input  logic [SHAMT_W-1:0]  sh,
    input  logic                cin,
    input  logic [HALF-1:0]     spill,
    output logic [HALF-1:0]     res_hi,
    output logic                cout
);

    logic [HALF:0] sum;

    always_comb begin
        sum    = '0;
        res_hi = '0;
        cout   = 1'b0;
        case (op)
            OP_ADD: begin
                sum    = {1'b0, a_hi} + {1'b0, b_hi} + {{HALF{1'b0}}, cin};
                res_hi = sum[HALF-1:0];
                cout   = sum[HALF];
            end
            OP_SUB: begin
                sum    = {1'b0, a_hi} + {1'b0, ~b_hi} + {{HALF{1'b0}}, cin};
                res_hi = sum[HALF-1:0];
                cout   = sum[HALF];
            end
            OP_AND: res_hi = a_hi & b_hi;
            OP_OR:  res_hi = a_hi | b_hi;
            OP_XOR: res_hi = a_hi ^ b_hi;
            OP_SHL: res_hi = (a_hi << sh) | spill;
            default: res_hi = '0;
        endcase
    end

endmodule

// File: rtl/stag_alu.sv
module stag_alu
    import stag_alu_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int SHAMT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [2:0]           in_op,
    input  logic [WIDTH-1:0]     in_a,
    input  logic [WIDTH-1:0]     in_b,
    input  logic                 in_fwd_a,
    output logic                 lo_valid,
    output logic [WIDTH/2-1:0]   lo_data,
    output logic                 hi_valid,
    output logic [WIDTH/2-1:0]   hi_data,
    output logic                 hi_cout
);

    localparam int HALF = WIDTH / 2;

    logic lo_live, hi_live;

    stag_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (in_valid),
        .lo_live (lo_live),
        .hi_live (hi_live)
    );

    // Stage 1 registers: lower half result plus everything the upper half needs.
    alu_op_e              s1_op;
    logic                 s1_fwd;
    logic [HALF-1:0]      s1_a_hi, s1_b_hi, s1_spill, lo_q;
    logic [SHAMT_W-1:0]   s1_sh;
    logic                 s1_carry;
    // Stage 2 registers.
    logic [HALF-1:0]      hi_q;
    logic                 cout_q;

    // A forward request counts only while a lower half is being presented.
    logic                 fwd_eff;
    logic [HALF-1:0]      a_lo_sel, a_hi_sel;
    alu_op_e              op_in;
    logic [HALF-1:0]      lo_n, spill_n, hi_n;
    logic                 carry_n, cout_n;

    assign fwd_eff  = in_fwd_a & lo_live;
    assign a_lo_sel = fwd_eff ? lo_q : in_a[HALF-1:0];
    // Upper forward: producer's upper half lands in hi_q at the edge the
    // dependent op issues, so it is ready when the dependent reaches stage 2.
    assign a_hi_sel = s1_fwd ? hi_q : s1_a_hi;
    assign op_in    = alu_op_e'(in_op);

    stag_lo_stage #(.HALF(HALF), .SHAMT_W(SHAMT_W)) u_lo (
        .op     (op_in),
        .a_lo   (a_lo_sel),
        .b_lo   (in_b[HALF-1:0]),
        .sh     (in_b[SHAMT_W-1:0]),
        .res_lo (lo_n),
        .carry  (carry_n),
        .spill  (spill_n)
    );

    stag_hi_stage #(.HALF(HALF), .SHAMT_W(SHAMT_W)) u_hi (
        .op     (s1_op),
        .a_hi   (a_hi_sel),
        .b_hi   (s1_b_hi),
        .sh     (s1_sh),
        .cin    (s1_carry),
        .spill  (s1_spill),
        .res_hi (hi_n),
        .cout   (cout_n)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op    <= OP_ADD;
            s1_fwd   <= 1'b0;
            s1_a_hi  <= '0;
            s1_b_hi  <= '0;
            s1_sh    <= '0;
            s1_carry <= 1'b0;
            s1_spill <= '0;
            lo_q     <= '0;
        end else if (in_valid) begin
            s1_op    <= op_in;
            s1_fwd   <= fwd_eff;
            s1_a_hi  <= in_a[WIDTH-1:HALF];
            s1_b_hi  <= in_b[WIDTH-1:HALF];
            s1_sh    <= in_b[SHAMT_W-1:0];
            s1_carry <= carry_n;
            s1_spill <= spill_n;
            lo_q     <= lo_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            cout_q <= 1'b0;
        end else if (lo_live) begin
            hi_q   <= hi_n;
            cout_q <= cout_n;
        end
    end

    assign lo_valid = lo_live;
    assign lo_data  = lo_q;
    assign hi_valid = hi_live;
    assign hi_data  = hi_q;
    assign hi_cout  = cout_q;

endmodule

// File: rtl/stag_alu_chk.sv
module stag_alu_chk #(
    parameter int WIDTH   = 32,
    parameter int SHAMT_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [2:0]           in_op,
    input logic [WIDTH-1:0]     in_a,
    input logic [WIDTH-1:0]     in_b,
    input logic                 in_fwd_a,
    input logic                 lo_valid,
    input logic [WIDTH/2-1:0]   lo_data,
    input logic                 hi_valid,
    input logic [WIDTH/2-1:0]   hi_data,
    input logic                 hi_cout
);

    localparam int HALF = WIDTH / 2;

    assert_lo_after_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> lo_valid);

    assert_lo_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !lo_valid);

    assert_hi_after_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lo_valid |=> hi_valid);

    assert_hi_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_valid |=> !hi_valid);

    assert_no_carry_logic_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 3'd2 || in_op == 3'd3 || in_op == 3'd4 || in_op == 3'd5))
        |=> ##1 (hi_valid && !hi_cout));

    assert_xor_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd4 && !(in_fwd_a && lo_valid))
        |=> (lo_data == $past(in_a[HALF-1:0] ^ in_b[HALF-1:0])));

    assert_fwd_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd3 && in_fwd_a && !lo_valid)
        |=> (lo_data == $past(in_a[HALF-1:0] | in_b[HALF-1:0])));

    assert_undef_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[2:1] == 2'b11) |=> (lo_data == '0));

endmodule

bind stag_alu stag_alu_chk #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_op    (in_op),
    .in_a     (in_a),
    .in_b     (in_b),
    .in_fwd_a (in_fwd_a),
    .lo_valid (lo_valid),
    .lo_data  (lo_data),
    .hi_valid (hi_valid),
    .hi_data  (hi_data),
    .hi_cout  (hi_cout)
);

// File: tb/stag_alu_bench.sv
`timescale 1ns/1ps
module stag_alu_bench;

    localparam int W  = 8;
    localparam int H  = W / 2;
    localparam int SW = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   in_op = '0;
    logic [W-1:0] in_a = '0, in_b = '0;
    logic         in_fwd_a = 1'b0;
    logic         lo_valid, hi_valid, hi_cout;
    logic [H-1:0] lo_data, hi_data;

    stag_alu #(.WIDTH(W), .SHAMT_W(SW)) u_stag_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_fwd_a(in_fwd_a),
        .lo_valid(lo_valid), .lo_data(lo_data), .hi_valid(hi_valid),
        .hi_data(hi_data), .hi_cout(hi_cout)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench-side pipeline of expected results: {cout, result}.
    bit         p1_v = 0, p2_v = 0;
    logic [W:0] p1_res = '0, p2_res = '0;
    int         p1_op = 0, p2_op = 0;
    string      p1_tag = "", p2_tag = "";

    function automatic logic [W:0] model(int op, logic [W-1:0] a, logic [W-1:0] b);
        logic [W:0] r;
        case (op)
            0: r = {1'b0, a} + {1'b0, b};
            1: r = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
            2: r = {1'b0, a & b};
            3: r = {1'b0, a | b};
            4: r = {1'b0, a ^ b};
            5: r = {1'b0, a << b[SW-1:0]};
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string op_tag(int op);
        case (op)
            0: return "R3";
            1: return "R4";
            2, 3, 4: return "R5";
            5: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_out();
        chk(lo_valid == p1_v, "R2", int'(lo_valid), int'(p1_v));
        chk(hi_valid == p2_v, "R2", int'(hi_valid), int'(p2_v));
        if (p1_v)
            chk(lo_data == p1_res[H-1:0], p1_tag, int'(lo_data), int'(p1_res[H-1:0]));
        if (p2_v) begin
            chk(hi_data == p2_res[W-1:H], p2_tag, int'(hi_data), int'(p2_res[W-1:H]));
            chk(hi_cout == p2_res[W], (p2_op <= 1) ? p2_tag : "R10",
                int'(hi_cout), int'(p2_res[W]));
        end
    endtask

    task automatic step(input bit v, input int op, input int a, input int b, input bit f);
        logic [W-1:0] a_eff;
        string tag;
        @(negedge clk);
        check_out();
        a_eff = (f && p1_v) ? p1_res[W-1:0] : W'(a);
        tag = f ? (p1_v ? "R7" : "R8") : op_tag(op);
        p2_v = p1_v; p2_res = p1_res; p2_op = p1_op; p2_tag = p1_tag;
        p1_v = v; p1_res = model(op, a_eff, W'(b)); p1_op = op; p1_tag = tag;
        in_valid = v; in_op = 3'(op); in_a = W'(a); in_b = W'(b); in_fwd_a = f;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        // R1: reset holds valids low even with issue asserted.
        in_valid = 1'b1; in_op = 3'd0; in_a = 8'hff; in_b = 8'h01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(lo_valid == 1'b0, "R1", int'(lo_valid), 0);
        chk(hi_valid == 1'b0, "R1", int'(hi_valid), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(lo_valid == 1'b0 && hi_valid == 1'b0, "R1", int'({lo_valid, hi_valid}), 0);

        // Sweep of every op code over all A and a spread of B, with bubbles.
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int j = 0; j < 16; j++) begin
                    step(1'b1, op, a, (j * 17 + (a & 3)) & 255, 1'b0);
                    if (((a + j) % 7) == 0) step(1'b0, 0, 0, 0, 1'b0);
                end
            end
        end

        // R7: dependent chains, each op forwarding the previous full result.
        for (int a = 0; a < 256; a++) begin
            step(1'b1, 0, a, 255 - a, 1'b0);
            step(1'b1, 0, 0, (a * 29) & 255, 1'b1);
            step(1'b1, 5, 0, a & 3, 1'b1);
            step(1'b1, 1, 0, (a * 53) & 255, 1'b1);
            step(1'b1, 4, 0, 8'h5a, 1'b1);
            step(1'b1, 0, 0, 8'h0f, 1'b1);
            step(1'b1, 3, 0, a & 8'h81, 1'b1);
            if ((a % 3) == 0) begin
                // R8: forward request with no lower half presented is ignored.
                step(1'b0, 0, 0, 0, 1'b0);
                step(1'b0, 0, 0, 0, 1'b0);
                step(1'b1, (a % 6 == 0) ? 3 : 0, a, 8'h3c, 1'b1);
            end
        end

        step(1'b0, 0, 0, 0, 1'b0);
        step(1'b0, 0, 0, 0, 1'b0);
        step(1'b0, 0, 0, 0, 1'b0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2: watchdog expired, actual running expected done");
        finish_run();
    end

endmodule